// File: doc/BRIEF.md
# Sector Load and Program Sequencer

This block is the device-side control of a byte-wide nonvolatile store that is only ever rewritten a whole sector at a time. It samples the active-low chip-select, write strobe and output enable, together with the address and data buses, on a fast system clock. All of these pass through a synchroniser first. A write strobe pulse captures one byte into a sector-sized staging buffer. When no new write strobe arrives within a set number of cycles, the sequencer starts a commit of fixed length. The commit erases the target sector in the storage array and then writes the staged bytes into it. Any offset that was not loaded in that window ends up holding all ones.

While a commit runs, every read returns a status word instead of array data, and write strobes are discarded. A single permit input stands in for an external protection check. When permit is low at the moment the window closes, the commit still takes its full time but leaves the array untouched. A load aimed at a different sector than the first load of the window is dropped, and a sticky error output is raised.

The load window and the commit length are parameters counted in clock cycles. The address width is a parameter too. The low `BYTE_AW` address bits pick the byte within a sector, and the upper bits pick the sector.

Top module: `sector_flash_ctrl`

## Requirements
- R1: With `ce_n` and `oe_n` low and `we_n` high, `dout_en` goes high and `dout` shows the byte stored at `addr`. A location never written since start-up reads FFh.
- R2: Whenever `ce_n` or `oe_n` is high, `dout_en` is low.
- R3: A load happens when `we_n` and `ce_n` are both low while `oe_n` is high. The address is taken at whichever of the two falling edges comes later. The data is taken at whichever rising edge comes first.
- R4: `addr[ADDR_W-1:BYTE_AW]` selects the sector and `addr[BYTE_AW-1:0]` selects the byte. Bytes may be loaded in any order, and each one lands at its own offset.
- R5: If the next load's falling edge comes within the window (`WINDOW_CYC` cycles) after the previous load's rising edge, loading continues and `busy` stays low. If no falling edge comes, `busy` rises about `WINDOW_CYC`+5 cycles after that rising edge.
- R6: `busy` stays high for exactly `TWC_CYC` cycles. During this time the addressed sector is first filled with FFh and then written with the loaded bytes. Bytes that were not loaded read FFh afterwards, and other sectors are left unchanged.
- R7: While `busy` is high, a read returns a status word. Bit 7 is the inverse of bit 7 of the last accepted load, and bits 6..0 are zero. After `busy` falls, reads return the stored data.
- R8: Write strobes while `busy` is high neither alter the buffer nor start another commit.
- R9: Within one window, a load whose sector differs from the first load's sector is ignored, and `sect_err` rises and stays high until reset.
- R10: If `permit` is low when the window closes, `busy` still lasts `TWC_CYC` cycles, but the array keeps its previous contents.
- R11: After reset, `busy`, `dout_en` and `sect_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address (sector in upper bits) |
| din | input | DATA_W | Write data |
| permit | input | 1 | High lets a commit change the array |
| dout | output | DATA_W | Read data or status word |
| dout_en | output | 1 | Output drive enable; low means high impedance |
| busy | output | 1 | Commit in progress |
| sect_err | output | 1 | Sticky flag for a cross-sector load |

## Verification
The bench builds the block with `ADDR_W`=11, `WINDOW_CYC`=40 and `TWC_CYC`=600. That gives eight 256-byte sectors, which is enough to show that a commit leaves neighbouring sectors alone and that cross-sector loads are rejected. With these values a window expiry and a complete erase-and-write commit take only a few hundred cycles, so the bench can repeat them for the permit, busy-write and strobe-ordering cases. It can also count the busy length at the port and sample status reads in the middle of a commit.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ERASE,
    ST_PROG,
    ST_HOLD
  } sfc_state_t;
endpackage

// File: rtl/sfc_ram.sv
module sfc_ram #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [DW-1:0] INIT = '1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfc_strobe_sync.sv
module sfc_strobe_sync #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int SYNC_ST = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_start,
  output logic          load_ev,
  output logic [AW-1:0] ld_addr,
  output logic [DW-1:0] ld_data,
  output logic          rd_act,
  output logic [AW-1:0] rd_addr
);
  localparam int PW = 3 + AW + DW;
  localparam logic [PW-1:0] PIPE_RST = {3'b111, {(AW + DW){1'b0}}};

  logic [PW-1:0] pipe [SYNC_ST];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= PIPE_RST;
    else     pipe[0] <= {oe_n, we_n, ce_n, addr, din};
  end

  for (genvar g = 1; g < SYNC_ST; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[g] <= PIPE_RST;
      else     pipe[g] <= pipe[g-1];
    end
  end

  logic          oe_s, we_s, ce_s;
  logic [AW-1:0] a_s;
  logic [DW-1:0] d_s;
  assign {oe_s, we_s, ce_s, a_s, d_s} = pipe[SYNC_ST-1];

  // write is active only while both strobes are low with output enable high
  logic w_act, w_act_d;
  assign w_act = ~ce_s & ~we_s & oe_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_act_d  <= 1'b0;
      wr_start <= 1'b0;
      load_ev  <= 1'b0;
      ld_addr  <= '0;
      ld_data  <= '0;
      rd_act   <= 1'b0;
      rd_addr  <= '0;
    end else begin
      w_act_d  <= w_act;
      wr_start <= w_act & ~w_act_d;
      load_ev  <= ~w_act & w_act_d;
      if (w_act & ~w_act_d) ld_addr <= a_s;   // later falling edge
      if (~w_act & w_act_d) ld_data <= d_s;   // first rising edge
      rd_act   <= ~ce_s & ~oe_s & we_s;
      rd_addr  <= a_s;
    end
  end
endmodule

// File: rtl/sfc_window.sv
module sfc_window #(
  parameter int WINDOW_CYC = 15000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic halt,
  output logic expire
);
  localparam int CW = $clog2(WINDOW_CYC + 1);

  logic [CW-1:0] cnt;
  logic          running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (halt) begin
        running <= 1'b0;
      end else if (arm) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (running) begin
        if (cnt == CW'(WINDOW_CYC - 1)) begin
          running <= 1'b0;
          expire  <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sector_flash_ctrl.sv
module sector_flash_ctrl
  import sfc_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int BYTE_AW    = 8,
  parameter int WINDOW_CYC = 15000,
  parameter int TWC_CYC    = 1000000,
  parameter int SYNC_ST    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              permit,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy,
  output logic              sect_err
);
  localparam int SECT  = 1 << BYTE_AW;
  localparam int SEC_W = ADDR_W - BYTE_AW;
  localparam int TWC_W = $clog2(TWC_CYC + 1);
  localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

  // synchronised strobe events
  logic              wr_start, load_ev, rd_act;
  logic [ADDR_W-1:0] ld_addr, rd_addr;
  logic [DATA_W-1:0] ld_data;

  sfc_strobe_sync #(.AW(ADDR_W), .DW(DATA_W), .SYNC_ST(SYNC_ST)) u_sync (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .wr_start(wr_start), .load_ev(load_ev),
    .ld_addr(ld_addr), .ld_data(ld_data), .rd_act(rd_act), .rd_addr(rd_addr)
  );

  sfc_state_t         state;
  logic [SEC_W-1:0]   cur_sec;
  logic [SECT-1:0]    vld;
  logic [BYTE_AW-1:0] idx, p_idx;
  logic [TWC_W-1:0]   twc;
  logic               perm_q, last_msb, p_v;

  logic accept, same_sec, buf_we, expire;
  logic [SEC_W-1:0]   ld_sec;
  logic [BYTE_AW-1:0] ld_byte;

  assign ld_sec   = ld_addr[ADDR_W-1:BYTE_AW];
  assign ld_byte  = ld_addr[BYTE_AW-1:0];
  assign accept   = (state == ST_IDLE) || (state == ST_LOAD);
  assign same_sec = (ld_sec == cur_sec);
  assign buf_we   = load_ev && ((state == ST_IDLE) || ((state == ST_LOAD) && same_sec));
  assign busy     = !accept;

  sfc_window #(.WINDOW_CYC(WINDOW_CYC)) u_win (
    .clk(clk), .rst(rst),
    .arm(load_ev && accept),
    .halt(wr_start && accept),
    .expire(expire)
  );

  // sector staging buffer
  logic [DATA_W-1:0] buf_rdata;

  sfc_ram #(.AW(BYTE_AW), .DW(DATA_W), .INIT(ERASED)) u_buf (
    .clk(clk), .we(buf_we), .waddr(ld_byte), .wdata(ld_data),
    .raddr(idx), .rdata(buf_rdata)
  );

  // storage array
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr;
  logic [DATA_W-1:0] arr_wdata, arr_rdata;

  always_comb begin
    arr_we    = 1'b0;
    arr_waddr = {cur_sec, p_idx};
    arr_wdata = buf_rdata;
    if (state == ST_ERASE) begin
      arr_we    = perm_q;
      arr_waddr = {cur_sec, idx};
      arr_wdata = ERASED;
    end else if (p_v) begin
      arr_we    = perm_q && vld[p_idx];
    end
  end

  sfc_ram #(.AW(ADDR_W), .DW(DATA_W), .INIT(ERASED)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(rd_addr), .rdata(arr_rdata)
  );

  // load capture and commit sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_sec  <= '0;
      vld      <= '0;
      idx      <= '0;
      p_idx    <= '0;
      p_v      <= 1'b0;
      twc      <= '0;
      perm_q   <= 1'b0;
      last_msb <= 1'b0;
      sect_err <= 1'b0;
    end else begin
      p_v   <= (state == ST_PROG);
      p_idx <= idx;
      case (state)
        ST_IDLE: begin
          if (load_ev) begin
            state        <= ST_LOAD;
            cur_sec      <= ld_sec;
            vld          <= '0;
            vld[ld_byte] <= 1'b1;
            last_msb     <= ld_data[DATA_W-1];
          end
        end
        ST_LOAD: begin
          if (load_ev) begin
            if (same_sec) begin
              vld[ld_byte] <= 1'b1;
              last_msb     <= ld_data[DATA_W-1];
            end else begin
              sect_err <= 1'b1;
            end
          end
          if (expire) begin
            state  <= ST_ERASE;
            idx    <= '0;
            twc    <= '0;
            perm_q <= permit;
          end
        end
        ST_ERASE: begin
          idx <= idx + BYTE_AW'(1);
          if (idx == BYTE_AW'(SECT - 1)) state <= ST_PROG;
        end
        ST_PROG: begin
          idx <= idx + BYTE_AW'(1);
          if (idx == BYTE_AW'(SECT - 1)) state <= ST_HOLD;
        end
        default: ;
      endcase
      if (busy) begin
        twc <= twc + TWC_W'(1);
        if (twc == TWC_W'(TWC_CYC - 1)) state <= ST_IDLE;
      end
    end
  end

  // registered read path
  logic rd_act_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_d <= 1'b0;
      dout_en  <= 1'b0;
      dout     <= '0;
    end else begin
      rd_act_d <= rd_act;
      dout_en  <= rd_act_d;
      dout     <= busy ? {~last_msb, {(DATA_W-1){1'b0}}} : arr_rdata;
    end
  end
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int DATA_W  = 8,
  parameter int TWC_CYC = 1000000
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              arr_we,
  input logic              buf_we,
  input logic              perm_q,
  input logic              sect_err,
  input logic              dout_en,
  input logic [DATA_W-1:0] dout
);
  localparam int CW = $clog2(TWC_CYC + 2);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + CW'(1);
    else           busy_cnt <= '0;
  end

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == CW'(TWC_CYC)));

  assert_arr_only_busy_R6: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  assert_status_low_bits_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && dout_en) |-> (dout[DATA_W-2:0] == '0));

  assert_no_buf_write_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !buf_we);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    $past(sect_err) |-> sect_err);

  assert_frozen_no_permit_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !perm_q) |-> !arr_we);
endmodule

bind sector_flash_ctrl sfc_checker #(.DATA_W(DATA_W), .TWC_CYC(TWC_CYC)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .arr_we(arr_we), .buf_we(buf_we),
  .perm_q(perm_q), .sect_err(sect_err), .dout_en(dout_en), .dout(dout)
);

// File: tb/tb_sector_flash_ctrl.sv
module tb_sector_flash_ctrl;
  localparam int AW  = 11;
  localparam int DW  = 8;
  localparam int WIN = 40;
  localparam int TWC = 600;
  localparam int NV  = 8;

  // {address, data}; sector 3, loaded out of order
  localparam logic [AW+DW-1:0] VEC [NV] = '{
    {11'h305, 8'hA5}, {11'h3F0, 8'h0F}, {11'h300, 8'h11}, {11'h3FF, 8'hFE},
    {11'h37A, 8'h7A}, {11'h312, 8'h00}, {11'h3C3, 8'hC3}, {11'h301, 8'h5C}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          ce_n, we_n, oe_n, permit;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_en, busy, sect_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sector_flash_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BYTE_AW(8),
                      .WINDOW_CYC(WIN), .TWC_CYC(TWC), .SYNC_ST(2)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .permit(permit), .dout(dout),
    .dout_en(dout_en), .busy(busy), .sect_err(sect_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d);
    tick(1);
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0;
    tick(3); we_n = 1'b0;
    tick(4); we_n = 1'b1;
    tick(3); ce_n = 1'b1;
    tick(2);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic e);
    tick(1);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    tick(7);
    d = dout; e = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    tick(6);
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] d;
    logic e;
    rd(a, d, e);
    check(req, {24'h0, d}, {24'h0, exp});
    check(req, {31'h0, e}, 32'h1);
  endtask

  task automatic wait_commit();
    tick(WIN + TWC + 40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; permit = 1'b1;
    addr = '0; din = '0; rst = 1'b1;
    tick(5);
    rst = 1'b0;
    tick(2);

    // R11 reset state
    check("R11 busy", {31'h0, busy}, 32'h0);
    check("R11 dout_en", {31'h0, dout_en}, 32'h0);
    check("R11 sect_err", {31'h0, sect_err}, 32'h0);

    // R1 erased location, R2 release
    rd_check("R1 fresh read", 11'h010, 8'hFF);
    check("R2 released", {31'h0, dout_en}, 32'h0);
    tick(1); addr = 11'h010; ce_n = 1'b0; oe_n = 1'b1; tick(8);
    check("R2 oe high", {31'h0, dout_en}, 32'h0);
    ce_n = 1'b1; oe_n = 1'b0; tick(8);
    check("R2 ce high", {31'h0, dout_en}, 32'h0);
    oe_n = 1'b1; tick(4);

    // R4 table walk: load out of order, commit, read back
    for (int i = 0; i < NV; i++) load(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
    wait_commit();
    for (int i = 0; i < NV; i++) rd_check("R4 table", VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
    rd_check("R6 unloaded", 11'h302, 8'hFF);
    rd_check("R6 other sector", 11'h205, 8'hFF);

    // R5 window, R7 status, R6 busy length
    load(11'h105, 8'h3C);
    tick(WIN / 2);
    check("R5 open", {31'h0, busy}, 32'h0);
    load(11'h106, 8'h42);
    tick(WIN - 20);
    check("R5 still open", {31'h0, busy}, 32'h0);
    begin
      int c = 0;
      for (int k = 0; k < WIN + TWC + 60; k++) begin
        @(negedge clk);
        if (busy) c++;
        if (k == 30) check("R5 expired", {31'h0, busy}, 32'h1);
        if (k == 40) begin addr = 11'h105; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0; end
        if (k == 48) begin
          check("R7 status", {24'h0, dout}, 32'h80);
          check("R7 status en", {31'h0, dout_en}, 32'h1);
          ce_n = 1'b1; oe_n = 1'b1;
        end
      end
      check("R6 busy length", c, TWC);
    end
    rd_check("R7 after", 11'h105, 8'h3C);
    rd_check("R7 after2", 11'h106, 8'h42);
    rd_check("R6 unloaded2", 11'h107, 8'hFF);

    // R8 strobes during busy are ignored
    load(11'h400, 8'h11);
    tick(WIN + 20);
    check("R8 busy", {31'h0, busy}, 32'h1);
    load(11'h401, 8'h22);
    load(11'h400, 8'h33);
    wait_commit();
    check("R8 no new commit", {31'h0, busy}, 32'h0);
    rd_check("R8 kept", 11'h400, 8'h11);
    rd_check("R8 dropped", 11'h401, 8'hFF);

    // R9 cross-sector load
    load(11'h500, 8'h55);
    load(11'h605, 8'h66);
    load(11'h501, 8'h77);
    check("R9 sect_err", {31'h0, sect_err}, 32'h1);
    wait_commit();
    check("R9 sticky", {31'h0, sect_err}, 32'h1);
    rd_check("R9 a", 11'h500, 8'h55);
    rd_check("R9 b", 11'h501, 8'h77);
    rd_check("R9 foreign", 11'h605, 8'hFF);
    rd_check("R9 offset", 11'h505, 8'hFF);

    // R10 permit low
    permit = 1'b0;
    load(11'h500, 8'h99);
    tick(WIN + 20);
    check("R10 busy", {31'h0, busy}, 32'h1);
    wait_commit();
    permit = 1'b1;
    rd_check("R10 unchanged", 11'h500, 8'h55);
    rd_check("R10 unchanged2", 11'h501, 8'h77);

    // R3 address at later falling edge, data at first rising edge
    tick(1);
    addr = 11'h710; din = 8'h01; oe_n = 1'b1; we_n = 1'b0;
    tick(3); ce_n = 1'b0;
    tick(3); addr = 11'h720; din = 8'h5A;
    tick(3); ce_n = 1'b1;
    tick(2); addr = 11'h730; din = 8'hEE;
    tick(2); we_n = 1'b1;
    tick(2);
    wait_commit();
    rd_check("R3 addr/data", 11'h710, 8'h5A);
    rd_check("R3 late addr", 11'h720, 8'hFF);
    rd_check("R3 after rise", 11'h730, 8'hFF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule